// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Doorbells

This block is a synchronous 1024 x 8 memory with two fully independent ports, called left and right. Either port can read or write any word on each clock edge, so two agents (for example two processors) can share a buffer without taking turns.

The two highest words double as mailboxes that ring a doorbell. The right port writes word 0x3FE to raise the left port's interrupt. The left port writes word 0x3FF to raise the right port's interrupt. An agent acknowledges its doorbell by reading its own mailbox word. The interrupt outputs are active low and come straight from flops. The mailbox words always hold ordinary data. When the mailbox enable input is low, the doorbells are off and the two words act as plain storage.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: After reset, both interrupt outputs are high (inactive) and both read-data outputs are 0x00.
- R2: A port reads when en=1, oe=1 and we=0. Its rdata shows the addressed word from the next clock edge. In every other cycle its rdata holds its previous value.
- R3: A port writes wdata to the addressed word at the clock edge when en=1 and we=1. If both ports write the same word in one cycle, the left port's byte is stored. A read on one port in the same cycle as a write by the other port to the same word returns the old contents.
- R4: With mailbox_en=1, a write by the right port to address 0x3FE drives l_irq_n low from the next edge.
- R5: With mailbox_en=1, a left-port access to address 0x3FE with en=1 and oe=1 drives l_irq_n high from the next edge. The value of we does not matter.
- R6: The right doorbell mirrors R4 and R5. A write by the left port to 0x3FF drives r_irq_n low. A right-port access to 0x3FF with en=1 and oe=1 drives r_irq_n high.
- R7: When a set and a clear of the same interrupt happen in the same cycle, the interrupt ends up asserted (low).
- R8: Words 0x3FE and 0x3FF store and return data like any other word, whether the mailbox function is on or off.
- R9: While mailbox_en=0, both interrupt outputs are high from the next edge and no write can raise them. After mailbox_en returns to 1, they stay high until a new doorbell write.
- R10: A port with en=0 writes nothing, leaves its rdata unchanged, and neither sets nor clears any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations sample on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mailbox_en | input | 1 | 1 turns the doorbell function on |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 10 | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, registered |
| l_irq_n | output | 1 | Left doorbell interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 10 | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, registered |
| r_irq_n | output | 1 | Right doorbell interrupt, active low |

## Verification
The assertions assume that every control input is a known 0 or 1 on each rising edge once reset is released. They also assume that the set and clear conditions derived from those inputs are exact, so an X on an enable would break their implications. The stimulus changes inputs only on falling edges. It draws every control bit as a clean 0 or 1 from a seeded generator and steers about half of all addresses onto the two mailbox words, so that sets, clears and collisions happen often. A same-word write by both ports is permitted, because the priority rule in R3 defines the result.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum int {
        PORT_L = 0,
        PORT_R = 1
    } port_idx_e;

    localparam int NUM_PORTS = 2;

    // Decoded intent of one port for one cycle.
    typedef struct packed {
        logic rd;         // read: enabled, output enabled, not writing
        logic wr;         // write: enabled and strobing
        logic ack_own;    // access of own mailbox that acknowledges it
        logic ring_peer;  // write to the peer's mailbox
    } port_dec_t;

endpackage

// File: rtl/dpm_port_dec.sv
module dpm_port_dec
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] OWN_BOX = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic              oe_i,
    input  logic [ADDR_W-1:0] addr_i,
    output port_dec_t         dec_o
);

    always_comb begin
        dec_o           = '0;
        dec_o.wr        = en_i && we_i;
        dec_o.rd        = en_i && oe_i && !we_i;
        dec_o.ack_own   = en_i && oe_i && (addr_i == OWN_BOX);
        dec_o.ring_peer = en_i && we_i && (addr_i == PEER_BOX);
    end

endmodule

// File: rtl/dpm_array.sv
module dpm_array
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0]               wr_i,
    input  logic [NUM_PORTS-1:0]               rd_i,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wdata_i,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [NUM_PORTS-1:0][DATA_W-1:0] rdata;
    } rd_state_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rd_state_t         rd_d;
    rd_state_t         rd_q;

    // Reads see the word as it stands before this edge's writes.
    always_comb begin
        rd_d = rd_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_i[p]) begin
                rd_d.rdata[p] = mem_q[addr_i[p]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    // Highest index is applied first, so the left port (index 0) wins a tie.
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_i[p]) begin
                mem_q[addr_i[p]] <= wdata_i[p];
            end
        end
    end

    assign rdata_o = rd_q.rdata;

    AST_LRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i[PORT_L] |=> $stable(rdata_o[PORT_L])); // R2
    AST_RRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i[PORT_R] |=> $stable(rdata_o[PORT_R])); // R10

endmodule

// File: rtl/dpm_flag.sv
module dpm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic mailbox_en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    typedef struct packed {
        logic pending;
    } flag_state_t;

    flag_state_t st_d;
    flag_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!mailbox_en_i) begin
            st_d.pending = 1'b0;
        end else if (set_i) begin
            st_d.pending = 1'b1;
        end else if (clr_i) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n_o = ~st_q.pending;

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        mailbox_en_i && set_i |=> !irq_n_o); // R4 R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        mailbox_en_i && clr_i && !set_i |=> irq_n_o); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mailbox_en_i |=> irq_n_o); // R9
    AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mailbox_en_i && !set_i && !clr_i |=> $stable(irq_n_o)); // R10

endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mailbox_en,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    localparam int                DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'(DEPTH - 1);

    logic [NUM_PORTS-1:0]             en_v, we_v, oe_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic [NUM_PORTS-1:0]             wr_v, rd_v, irq_n_v;
    port_dec_t                        dec [NUM_PORTS];

    assign en_v    = {r_en, l_en};
    assign we_v    = {r_we, l_we};
    assign oe_v    = {r_oe, l_oe};
    assign addr_v  = {r_addr, l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == PORT_L) ? L_BOX : R_BOX;
        localparam logic [ADDR_W-1:0] PEER = (p == PORT_L) ? R_BOX : L_BOX;

        dpm_port_dec #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .en_i   (en_v[p]),
            .we_i   (we_v[p]),
            .oe_i   (oe_v[p]),
            .addr_i (addr_v[p]),
            .dec_o  (dec[p])
        );

        assign wr_v[p] = dec[p].wr;
        assign rd_v[p] = dec[p].rd;

        // Raised by the other port's doorbell write, cleared by this port.
        dpm_flag u_flag (
            .clk          (clk),
            .rst_n        (rst_n),
            .mailbox_en_i (mailbox_en),
            .set_i        (dec[NUM_PORTS-1-p].ring_peer),
            .clr_i        (dec[p].ack_own),
            .irq_n_o      (irq_n_v[p])
        );
    end

    dpm_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_v),
        .rd_i    (rd_v),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .rdata_o (rdata_v)
    );

    assign l_rdata = rdata_v[PORT_L];
    assign r_rdata = rdata_v[PORT_R];
    assign l_irq_n = irq_n_v[PORT_L];
    assign r_irq_n = irq_n_v[PORT_R];

    AST_RDOOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mailbox_en && l_en && l_we && (l_addr == R_BOX) |=> !r_irq_n); // R6
    AST_LDOOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mailbox_en && r_en && r_we && (r_addr == L_BOX) |=> !l_irq_n); // R4
    AST_IDLE_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !l_en && !r_en |=> $stable(l_rdata) && $stable(r_rdata)); // R10

endmodule

// File: tb/tb_dpm_mailbox_ram.sv
module tb_dpm_mailbox_ram;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LBOX = 10'h3FE;
    localparam logic [AW-1:0] RBOX = 10'h3FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mailbox_en = 1'b0;
    logic l_en = 0, l_we = 0, l_oe = 0;
    logic r_en = 0, r_we = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_lrd = '0, m_rrd = '0;
    bit m_lf = 0, m_rf = 0;

    always #2 clk = ~clk;

    dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .mailbox_en(mailbox_en),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Next state of the model from the inputs now applied.
    task automatic model_step();
        bit lset, lclr, rset, rclr;
        logic [DW-1:0] lrd_n, rrd_n;
        lrd_n = (l_en && l_oe && !l_we) ? m_mem[l_addr] : m_lrd;
        rrd_n = (r_en && r_oe && !r_we) ? m_mem[r_addr] : m_rrd;
        lset = r_en && r_we && (r_addr == LBOX);
        lclr = l_en && l_oe && (l_addr == LBOX);
        rset = l_en && l_we && (l_addr == RBOX);
        rclr = r_en && r_oe && (r_addr == RBOX);
        if (!mailbox_en)  m_lf = 0;
        else if (lset)    m_lf = 1;
        else if (lclr)    m_lf = 0;
        if (!mailbox_en)  m_rf = 0;
        else if (rset)    m_rf = 1;
        else if (rclr)    m_rf = 0;
        if (r_en && r_we) m_mem[r_addr] = r_wdata;
        if (l_en && l_we) m_mem[l_addr] = l_wdata;
        m_lrd = lrd_n;
        m_rrd = rrd_n;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2 l_rdata"}, 32'(l_rdata), 32'(m_lrd));
        chk({tag, " R2 r_rdata"}, 32'(r_rdata), 32'(m_rrd));
        chk({tag, " R4 R5 l_irq_n"}, 32'(l_irq_n), 32'(!m_lf));
        chk({tag, " R6 r_irq_n"}, 32'(r_irq_n), 32'(!m_rf));
    endtask

    // Inputs are already applied; advance one edge and compare.
    task automatic tick(input string tag);
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic drive_l(input bit en, we, oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_en = en; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
    endtask

    task automatic drive_r(input bit en, we, oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_en = en; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        drive_l(0, 0, 0, '0, '0);
        drive_r(0, 0, 0, '0, '0);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int sel = $urandom_range(0, 9);
        if (sel < 3) return LBOX;
        if (sel < 5) return RBOX;
        if (sel < 8) return AW'($urandom_range(0, 7));
        return AW'($urandom_range(0, DEPTH - 1));
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 reset");

        // Fill memory with a known pattern, doorbells off.
        for (int i = 0; i < DEPTH; i++) begin
            drive_l(1, 1, 0, AW'(i), DW'(i * 7 + 3));
            tick("R3 fill");
        end
        idle();
        mailbox_en = 1'b1;
        tick("R9 enable");

        // Left doorbell set by right write, cleared by left read.
        drive_r(1, 1, 0, LBOX, 8'hA5);
        tick("R4 set");
        chk("R4 l_irq_n low", 32'(l_irq_n), 32'h0);
        idle();
        drive_l(1, 0, 1, LBOX, '0);
        tick("R5 clear");
        chk("R5 l_irq_n high", 32'(l_irq_n), 32'h1);
        chk("R8 mailbox data", 32'(l_rdata), 32'hA5);

        // Right doorbell; clear by an access with write strobe high.
        idle();
        drive_l(1, 1, 0, RBOX, 8'h5A);
        tick("R6 set");
        chk("R6 r_irq_n low", 32'(r_irq_n), 32'h0);
        idle();
        drive_r(1, 1, 1, RBOX, 8'h3C);
        tick("R6 clear we=1");
        chk("R6 r_irq_n high", 32'(r_irq_n), 32'h1);

        // Set and clear in the same cycle.
        idle();
        drive_r(1, 1, 0, LBOX, 8'h11);
        tick("R7 pre");
        drive_r(1, 1, 0, LBOX, 8'h22);
        drive_l(1, 0, 1, LBOX, '0);
        tick("R7 same cycle");
        chk("R7 set wins", 32'(l_irq_n), 32'h0);

        // Disabled port does nothing.
        idle();
        drive_l(1, 0, 1, LBOX, '0);
        tick("R10 clear prep");
        idle();
        drive_r(0, 1, 1, LBOX, 8'hEE);
        drive_l(0, 1, 1, RBOX, 8'hDD);
        tick("R10 disabled");
        chk("R10 no set", 32'(l_irq_n), 32'h1);
        idle();
        drive_r(1, 0, 1, LBOX, '0);
        tick("R10 readback");
        chk("R10 no write", 32'(r_rdata), 32'h22);

        // Mailbox function off.
        idle();
        drive_r(1, 1, 0, LBOX, 8'h77);
        tick("R9 pre");
        idle();
        mailbox_en = 1'b0;
        drive_l(1, 1, 0, RBOX, 8'h99);
        tick("R9 off");
        chk("R9 l_irq_n high", 32'(l_irq_n), 32'h1);
        chk("R9 r_irq_n high", 32'(r_irq_n), 32'h1);
        idle();
        mailbox_en = 1'b1;
        drive_r(1, 0, 1, RBOX, '0);
        tick("R9 re-enable");
        chk("R9 still high", 32'(r_irq_n), 32'h1);
        chk("R8 plain word", 32'(r_rdata), 32'h99);

        // Collision and read-during-write.
        idle();
        drive_l(1, 1, 0, 10'h055, 8'hC1);
        drive_r(1, 1, 0, 10'h055, 8'hC2);
        tick("R3 collide");
        idle();
        drive_r(1, 0, 1, 10'h055, '0);
        tick("R3 collide read");
        chk("R3 left wins", 32'(r_rdata), 32'hC1);
        drive_l(1, 1, 0, 10'h055, 8'h4B);
        drive_r(1, 0, 1, 10'h055, '0);
        tick("R3 rdw");
        chk("R3 old data", 32'(r_rdata), 32'hC1);

        // Constrained random.
        for (int n = 0; n < 4000; n++) begin
            mailbox_en = ($urandom_range(0, 7) != 0);
            drive_l($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, pick_addr(), DW'($urandom));
            drive_r($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, pick_addr(), DW'($urandom));
            tick("rand");
        end

        idle();
        finish_run();
    end

endmodule